// File: doc/BRIEF.md
# Character Screen Edit Sequencer

This block carries out terminal-style edits on a character screen held in an external single-port RAM of 80 columns by 25 rows. An upstream escape-sequence decoder hands it one command at a time. The commands are: put a character, carriage return, line feed, insert line, delete line, and erase to end of line. The block owns the cursor row and column registers. It turns each command into a series of RAM accesses, one access per clock, and holds `busy` high until the series is complete.

The RAM is addressed as `row*80 + col`. It returns read data one clock after the address is presented. A row copy takes two clocks per column: the source cell is read, and in the next clock that returned data is written into the same column of the neighbouring row. Every sweep walks the columns in ascending order and ends at column 79. Line clears follow the same order, so a single column counter serves all flows. Insert, delete, erase and scroll never move the cursor.

FSM states:
- `ST_IDLE`: waits for a command. Cursor-only commands complete here.
- `ST_PUT`: writes one character.
- `ST_COPY_RD` and `ST_COPY_WR`: the read half and the write half of one copied cell.
- `ST_FILL`: writes blanks.

FSM transitions:
- `ST_IDLE` goes to `ST_PUT` on a put command.
- `ST_IDLE` goes to `ST_COPY_RD` on an insert or delete above row 24, and on a line feed at row 24 (a scroll).
- `ST_IDLE` goes to `ST_FILL` on an erase, and on an insert or delete at row 24.
- `ST_PUT` goes to `ST_COPY_RD` when it wraps at the bottom row. Otherwise it goes to `ST_IDLE`.
- `ST_COPY_RD` always goes to `ST_COPY_WR`.
- `ST_COPY_WR` goes back to `ST_COPY_RD` until it reaches the last column of the last moved row. It then goes to `ST_FILL`.
- `ST_FILL` goes to `ST_IDLE` after column 79.

Top module: `scr_edit_engine`

## Requirements
- R1: After reset the cursor is at row 0, column 0, and `busy` is low. `cmd_ready` always equals the inverse of `busy`. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. The opcode encoding on `cmd_op` is: 0 put, 1 carriage return, 2 line feed, 3 insert line, 4 delete line, 5 erase to end of line.
- R2: A put writes `cmd_char` to address row*80+col, then advances the column by one. It is busy for exactly 1 cycle.
- R3: A put at column 79 sets the column to 0 and then performs a line feed, with the same effect as R4 or R5.
- R4: A carriage return sets the column to 0. A line feed on rows 0 to 23 increments the row. Neither is busy for any cycle, and neither changes the other cursor field.
- R5: A line feed at row 24 scrolls the screen: every row r from 0 to 23 takes the old content of row r+1. Row 24 is then blanked with 0x20 in all 80 columns, whatever the cursor column. The cursor is unchanged. The flow is busy for 24*160+80 cycles.
- R6: An insert at row r (r<24) moves each row k with k>r to hold the old content of row k-1. Row r is blanked with 0x20 and the old row 24 is lost. The cursor is unchanged. The flow is busy for (24-r)*160+80 cycles.
- R7: A delete at row r (r<24) moves each row k with r<=k<24 to hold the old content of row k+1. Row 24 is blanked with 0x20. The cursor is unchanged. The flow is busy for (24-r)*160+80 cycles.
- R8: At row 24, an insert and a delete each only blank row 24, and each is busy for 80 cycles. At row 23, each moves exactly one row and is busy for 240 cycles.
- R9: An erase to end of line blanks columns col to 79 of the cursor row with 0x20. It leaves the cursor row and column unchanged. It is busy for 80-col cycles.
- R10: A line feed followed by a carriage return leaves the same cursor and screen as a carriage return followed by a line feed.
- R11: Within a flow, successive writes step through the columns in ascending order and wrap from 79 to 0. Every copy write goes to the same column one row above or below the cell read in the previous clock, and carries exactly the value held at that cell.
- R12: Opcodes 6 and 7 are accepted but have no effect: no busy cycle, no RAM write and no cursor change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (not busy) |
| cmd_op | input | 3 | Command opcode |
| cmd_char | input | 8 | Character for put |
| busy | output | 1 | A RAM flow is in progress |
| cur_row | output | 5 | Cursor row |
| cur_col | output | 7 | Cursor column |
| mem_addr | output | 11 | RAM address, row*80+col |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one clock after address |

## Verification
Carriage return, line feed below the last row and the unused opcodes are due at the first sample after the accepting edge, with `busy` never high. A put is busy for one cycle, and its write lands on the edge that ends that cycle. Copy flows are busy for 160 cycles per moved row plus 80 cycles of fill, and an erase is busy for 80-col cycles. The bench model predicts that count for every command and samples `busy` and `cmd_ready` at each falling edge until the count is used up. It then compares the cursor and the whole screen only after `busy` has dropped.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_PUT = 3'd0;
    localparam logic [OP_W-1:0] OP_CR  = 3'd1;
    localparam logic [OP_W-1:0] OP_LF  = 3'd2;
    localparam logic [OP_W-1:0] OP_INS = 3'd3;
    localparam logic [OP_W-1:0] OP_DEL = 3'd4;
    localparam logic [OP_W-1:0] OP_EOL = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUT,
        ST_COPY_RD,
        ST_COPY_WR,
        ST_FILL
    } state_e;

endpackage

// File: rtl/scr_col_sweep.sv
module scr_col_sweep #(
    parameter int COLS = 80,
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_col,
    input  logic          step,
    output logic [CW-1:0] col,
    output logic          last
);

    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    logic [CW-1:0] col_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (load) begin
            col_q <= load_col;
        end else if (step) begin
            col_q <= (col_q == LAST_COL) ? '0 : col_q + 1'b1;
        end
    end

    assign col  = col_q;
    assign last = (col_q == LAST_COL);

    // R11: the shared column counter never leaves the row
    assert_col_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= LAST_COL);

endmodule

// File: rtl/scr_addr_map.sv
module scr_addr_map #(
    parameter int COLS = 80,
    parameter int ROWS = 25,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS),
    localparam int AW = $clog2(COLS * ROWS)
) (
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    output logic [AW-1:0] addr
);

    always_comb begin
        addr = AW'(row) * AW'(COLS) + AW'(col);
    end

endmodule

// File: rtl/scr_edit_ctrl.sv
module scr_edit_ctrl
    import scr_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 25,
    parameter logic [7:0] BLANK = 8'h20,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic [7:0]      cmd_char,
    input  logic [CW-1:0]   sw_col,
    input  logic            sw_last,
    input  logic [7:0]      mem_rdata,
    output logic            sw_load,
    output logic [CW-1:0]   sw_load_col,
    output logic            sw_step,
    output logic [RW-1:0]   acc_row,
    output logic [CW-1:0]   acc_col,
    output logic            mem_we,
    output logic [7:0]      mem_wdata,
    output logic            busy,
    output logic [RW-1:0]   cur_row,
    output logic [CW-1:0]   cur_col
);

    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    state_e        state_q, state_d;
    logic [RW-1:0] row_q, row_d;
    logic [CW-1:0] col_q, col_d;
    logic [RW-1:0] work_q, work_d;
    logic [RW-1:0] fill_q, fill_d;
    logic          ins_q, ins_d;
    logic [7:0]    char_q, char_d;
    logic          accept;

    assign accept = cmd_valid && (state_q == ST_IDLE);

    // next-state and datapath decisions
    always_comb begin
        state_d     = state_q;
        row_d       = row_q;
        col_d       = col_q;
        work_d      = work_q;
        fill_d      = fill_q;
        ins_d       = ins_q;
        char_d      = char_q;
        sw_load     = 1'b0;
        sw_load_col = '0;
        sw_step     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    case (cmd_op)
                        OP_PUT: begin
                            char_d  = cmd_char;
                            state_d = ST_PUT;
                        end
                        OP_CR: col_d = '0;
                        OP_LF: begin
                            if (row_q < LAST_ROW) begin
                                row_d = row_q + 1'b1;
                            end else begin
                                state_d = ST_COPY_RD;
                                work_d  = '0;
                                ins_d   = 1'b0;
                                sw_load = 1'b1;
                            end
                        end
                        OP_INS: begin
                            sw_load = 1'b1;
                            if (row_q == LAST_ROW) begin
                                state_d = ST_FILL;
                                fill_d  = LAST_ROW;
                            end else begin
                                state_d = ST_COPY_RD;
                                work_d  = LAST_ROW;
                                ins_d   = 1'b1;
                            end
                        end
                        OP_DEL: begin
                            sw_load = 1'b1;
                            if (row_q == LAST_ROW) begin
                                state_d = ST_FILL;
                                fill_d  = LAST_ROW;
                            end else begin
                                state_d = ST_COPY_RD;
                                work_d  = row_q;
                                ins_d   = 1'b0;
                            end
                        end
                        OP_EOL: begin
                            state_d     = ST_FILL;
                            fill_d      = row_q;
                            sw_load     = 1'b1;
                            sw_load_col = col_q;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PUT: begin
                if (col_q == LAST_COL) begin
                    col_d = '0;
                    if (row_q < LAST_ROW) begin
                        row_d   = row_q + 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_COPY_RD;
                        work_d  = '0;
                        ins_d   = 1'b0;
                        sw_load = 1'b1;
                    end
                end else begin
                    col_d   = col_q + 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_COPY_RD: begin
                state_d = ST_COPY_WR;
            end
            ST_COPY_WR: begin
                sw_step = 1'b1;
                state_d = ST_COPY_RD;
                if (sw_last) begin
                    if (ins_q) begin
                        if (work_q == row_q + 1'b1) begin
                            state_d = ST_FILL;
                            fill_d  = row_q;
                        end else begin
                            work_d = work_q - 1'b1;
                        end
                    end else begin
                        if (work_q == LAST_ROW - 1'b1) begin
                            state_d = ST_FILL;
                            fill_d  = LAST_ROW;
                        end else begin
                            work_d = work_q + 1'b1;
                        end
                    end
                end
            end
            ST_FILL: begin
                sw_step = 1'b1;
                if (sw_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            work_q  <= '0;
            fill_q  <= '0;
            ins_q   <= 1'b0;
            char_q  <= BLANK;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            col_q   <= col_d;
            work_q  <= work_d;
            fill_q  <= fill_d;
            ins_q   <= ins_d;
            char_q  <= char_d;
        end
    end

    // outputs
    always_comb begin
        acc_row   = row_q;
        acc_col   = col_q;
        mem_we    = 1'b0;
        mem_wdata = BLANK;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUT: begin
                mem_we    = 1'b1;
                mem_wdata = char_q;
            end
            ST_COPY_RD: begin
                acc_row = ins_q ? work_q - 1'b1 : work_q + 1'b1;
                acc_col = sw_col;
            end
            ST_COPY_WR: begin
                acc_row   = work_q;
                acc_col   = sw_col;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            ST_FILL: begin
                acc_row = fill_q;
                acc_col = sw_col;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign cur_row = row_q;
    assign cur_col = col_q;

    // R2: cursor stays inside the screen
    assert_cursor_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q <= LAST_ROW) && (col_q <= LAST_COL));

    // R9 (also R5, R6, R7): copy and fill flows leave the cursor untouched
    assert_cursor_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COPY_RD || state_q == ST_COPY_WR || state_q == ST_FILL)
        |=> ($stable(row_q) && $stable(col_q)));

    // R11: a copy write lands in the read column of the adjacent row
    assert_copy_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COPY_WR) |->
        (acc_col == $past(acc_col)) &&
        ((acc_row == $past(acc_row) + 1'b1) || (acc_row + 1'b1 == $past(acc_row))));

endmodule

// File: rtl/scr_edit_engine.sv
module scr_edit_engine
    import scr_pkg::*;
#(
    parameter int COLS = 80,
    parameter int ROWS = 25,
    parameter logic [7:0] BLANK = 8'h20,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS),
    localparam int AW = $clog2(COLS * ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [OP_W-1:0] cmd_op,
    input  logic [7:0]      cmd_char,
    output logic            busy,
    output logic [RW-1:0]   cur_row,
    output logic [CW-1:0]   cur_col,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata
);

    logic          sw_load;
    logic [CW-1:0] sw_load_col;
    logic          sw_step;
    logic [CW-1:0] sw_col;
    logic          sw_last;
    logic [RW-1:0] acc_row;
    logic [CW-1:0] acc_col;

    scr_edit_ctrl #(.COLS(COLS), .ROWS(ROWS), .BLANK(BLANK)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_char    (cmd_char),
        .sw_col      (sw_col),
        .sw_last     (sw_last),
        .mem_rdata   (mem_rdata),
        .sw_load     (sw_load),
        .sw_load_col (sw_load_col),
        .sw_step     (sw_step),
        .acc_row     (acc_row),
        .acc_col     (acc_col),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .cur_row     (cur_row),
        .cur_col     (cur_col)
    );

    scr_col_sweep #(.COLS(COLS)) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sw_load),
        .load_col (sw_load_col),
        .step     (sw_step),
        .col      (sw_col),
        .last     (sw_last)
    );

    scr_addr_map #(.COLS(COLS), .ROWS(ROWS)) u_map (
        .row  (acc_row),
        .col  (acc_col),
        .addr (mem_addr)
    );

    assign cmd_ready = !busy;

    // R2: every write targets a cell of the screen
    assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) < COLS * ROWS));

endmodule

// File: tb/tb_scr_edit_engine.sv
module tb_scr_edit_engine;

    localparam int CLK_PERIOD = 10;
    localparam int COLS  = 80;
    localparam int ROWS  = 25;
    localparam int NCELL = COLS * ROWS;
    localparam int LROW  = ROWS - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_char = 8'h00;
    logic        busy;
    logic [4:0]  cur_row;
    logic [6:0]  cur_col;
    logic [10:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    logic [7:0] ram [NCELL];
    int model [NCELL];
    int mrow = 0, mcol = 0;
    int n_chk = 0, n_err = 0;
    bit finished = 0;
    int sw_viol = 0, sw_pairs = 0;
    bit trk_valid = 0, prev_rd = 0;
    int last_col = 0, prev_addr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scr_edit_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_char(cmd_char), .busy(busy), .cur_row(cur_row),
        .cur_col(cur_col), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // behavioural RAM, read data one clock later
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    // sweep-order and copy-pair monitor (R11)
    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (mem_we) begin
                int c;
                c = int'(mem_addr) % COLS;
                if (trk_valid && c != ((last_col == COLS-1) ? 0 : last_col + 1)) sw_viol++;
                if (prev_rd) begin
                    sw_pairs++;
                    if ((int'(mem_addr) != prev_addr + COLS && int'(mem_addr) + COLS != prev_addr)
                        || mem_wdata !== ram[prev_addr]) sw_viol++;
                end
                trk_valid = 1;
                last_col  = c;
            end
            prev_rd   = !mem_we;
            prev_addr = int'(mem_addr);
        end else begin
            trk_valid = 0;
            prev_rd   = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic m_blank(input int r, input int from);
        for (int c = from; c < COLS; c++) model[r*COLS + c] = 32'h20;
    endtask

    task automatic m_copy(input int src, input int dst);
        for (int c = 0; c < COLS; c++) model[dst*COLS + c] = model[src*COLS + c];
    endtask

    task automatic m_lf(output int n);
        if (mrow < LROW) begin
            mrow++;
            n = 0;
        end else begin
            for (int r = 0; r < LROW; r++) m_copy(r + 1, r);
            m_blank(LROW, 0);
            n = LROW * 2 * COLS + COLS;
        end
    endtask

    task automatic m_apply(input logic [2:0] op, input logic [7:0] ch, output int n);
        n = 0;
        case (op)
            3'd0: begin
                model[mrow*COLS + mcol] = int'(ch);
                if (mcol == COLS - 1) begin
                    mcol = 0;
                    m_lf(n);
                    n = n + 1;
                end else begin
                    mcol++;
                    n = 1;
                end
            end
            3'd1: mcol = 0;
            3'd2: m_lf(n);
            3'd3: begin
                for (int k = LROW; k > mrow; k--) m_copy(k - 1, k);
                m_blank(mrow, 0);
                n = (LROW - mrow) * 2 * COLS + COLS;
            end
            3'd4: begin
                for (int k = mrow; k < LROW; k++) m_copy(k + 1, k);
                m_blank(LROW, 0);
                n = (LROW - mrow) * 2 * COLS + COLS;
            end
            3'd5: begin
                m_blank(mrow, mcol);
                n = COLS - mcol;
            end
            default: n = 0;
        endcase
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [7:0] ch, input string tag);
        int n, mism, bad;
        m_apply(op, ch, n);
        @(negedge clk);
        check(cmd_ready === 1'b1, "R1", "ready before command", int'(cmd_ready), 1);
        cmd_op = op;
        cmd_char = ch;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        mism = 0;
        for (int k = 0; k < n; k++) begin
            if (busy !== 1'b1 || cmd_ready !== 1'b0) mism++;
            @(negedge clk);
        end
        if (busy !== 1'b0 || cmd_ready !== 1'b1) mism++;
        check(mism == 0, tag, "busy cycle mismatches", mism, 0);
        check(int'(cur_row) == mrow && int'(cur_col) == mcol, tag, "cursor row*100+col",
              int'(cur_row) * 100 + int'(cur_col), mrow * 100 + mcol);
        bad = 0;
        for (int i = 0; i < NCELL; i++) if (ram[i] !== model[i][7:0]) bad++;
        check(bad == 0, tag, "screen cell mismatches", bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCELL; i++) begin
            model[i] = ((i * 7 + i / COLS) % 94) + 33;
            ram[i] = model[i][7:0];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cur_row == 0 && cur_col == 0, "R1", "reset cursor", int'(cur_row)*100 + int'(cur_col), 0);
        check(busy === 1'b0, "R1", "reset busy", int'(busy), 0);
        check(cmd_ready === 1'b1, "R1", "reset ready", int'(cmd_ready), 1);

        do_cmd(3'd0, "A", "R2");
        do_cmd(3'd0, "B", "R2");
        do_cmd(3'd6, "x", "R12");
        do_cmd(3'd7, "y", "R12");
        for (int i = 0; i < 3; i++) do_cmd(3'd2, 8'h00, "R4");
        do_cmd(3'd1, 8'h00, "R4");
        for (int i = 0; i < 5; i++) do_cmd(3'd0, 8'h61 + 8'(i), "R2");
        do_cmd(3'd5, 8'h00, "R9");
        do_cmd(3'd3, 8'h00, "R6");
        do_cmd(3'd4, 8'h00, "R7");
        for (int i = 0; i < 10; i++) do_cmd(3'd2, 8'h00, "R4");
        do_cmd(3'd2, 8'h00, "R10");
        do_cmd(3'd1, 8'h00, "R10");
        for (int i = 0; i < 3; i++) do_cmd(3'd0, 8'h4b, "R2");
        do_cmd(3'd1, 8'h00, "R10");
        do_cmd(3'd2, 8'h00, "R10");
        for (int i = 0; i < COLS; i++) do_cmd(3'd0, 8'h30 + 8'(i % 10), "R3");
        for (int i = 0; i < 7; i++) do_cmd(3'd2, 8'h00, "R4");
        for (int i = 0; i < 4; i++) do_cmd(3'd0, 8'h5a, "R2");
        do_cmd(3'd3, 8'h00, "R8");
        do_cmd(3'd4, 8'h00, "R8");
        do_cmd(3'd2, 8'h00, "R4");
        do_cmd(3'd3, 8'h00, "R8");
        do_cmd(3'd4, 8'h00, "R8");
        do_cmd(3'd5, 8'h00, "R9");
        do_cmd(3'd2, 8'h00, "R5");
        do_cmd(3'd1, 8'h00, "R4");
        for (int i = 0; i < COLS; i++) do_cmd(3'd0, 8'h41 + 8'(i % 26), "R3");

        check(sw_viol == 0, "R11", "sweep order violations", sw_viol, 0);
        check(sw_pairs > 0, "R11", "copy pairs seen", sw_pairs, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule